// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block turns five status conditions into one interrupt request line. Each condition has its own enable bit in an 8-bit mask register that the host writes. A condition and its enable bit always share the same bit position. The block ANDs each condition with its enable bit, ORs the five results, and registers the result onto the interrupt output.

Two of the conditions are levels: receiver inhibited and transmitter available. They follow their inputs directly. The other three are sticky flags that a one-cycle event pulse sets: excessive NAK, reconfiguration timeout and new next ID. Each sticky flag has its own clear path. The clear-flags command clears the reconfiguration flag. The power-on clear-flags command clears the excessive-NAK flag. A read strobe on the next-ID register clears the new-next-ID flag.

Clearing a mask bit hides its source but leaves the condition untouched. If the condition is still present when the mask bit is set again, the interrupt returns. The current status word and the stored mask are both brought out so the host can read them.

Top module: `irq_aggregator`

## Requirements
- R1: Only mask bits 0, 2, 3, 6 and 7 are stored; the other three positions always read 0 and ignore written values, and only these five sources can raise the interrupt.
- R2: Bit positions in both `status_word` and the mask: 0 transmitter available, 2 excessive NAK, 3 reconfiguration timeout, 6 new next ID, 7 receiver inhibited; a mask bit of 1 enables its source.
- R3: `irq` is the OR of the five status-AND-mask terms, registered, so it changes one clock after the status or mask change that causes it.
- R4: Clearing a mask bit deasserts `irq` for that source without clearing the condition; setting the mask bit again while the condition persists reasserts `irq`.
- R5: The reconfiguration-timeout flag is set by `ev_recon_timeout` and cleared only by `clr_flags_cmd`.
- R6: The excessive-NAK flag is set by `ev_excess_nak` and cleared only by `por_clr_flags_cmd`.
- R7: The new-next-ID flag is set by `ev_new_next_id` and cleared only by `next_id_rd`.
- R8: Receiver inhibited and transmitter available appear in `status_word` in the same cycle as their inputs, with no storage.
- R9: When a set event and its clear strobe arrive in the same cycle, the flag ends up set.
- R10: `soft_rst` clears the mask to zero and takes priority over a write in the same cycle; it leaves the sticky flags unchanged.
- R11: `rst` clears the mask, all sticky flags and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous software reset of the mask |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 8 | Mask write value |
| mask_rd | output | 8 | Stored mask, unused bits 0 |
| rx_inhibit_lvl | input | 1 | Receiver inhibited level |
| tx_avail_lvl | input | 1 | Transmitter available level |
| ev_excess_nak | input | 1 | Excessive-NAK event pulse |
| ev_recon_timeout | input | 1 | Reconfiguration-timeout event pulse |
| ev_new_next_id | input | 1 | New-next-ID event pulse |
| clr_flags_cmd | input | 1 | Clear-flags command pulse |
| por_clr_flags_cmd | input | 1 | Power-on clear-flags command pulse |
| next_id_rd | input | 1 | Read strobe of the next-ID register |
| status_word | output | 8 | Current status bits at their positions |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event and clear inputs are synchronous to `clk` and that each strobe is a single-cycle pulse. The assertions also assume that the level inputs change only between clock edges. The bench drives every input just after a rising edge and holds each pulse for exactly one cycle. It also covers the same-cycle overlap of a set pulse and its clear pulse, so the priority assertion is exercised under the one overlap it covers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W          = 8;
  localparam int POS_TX_AVAIL   = 0;
  localparam int POS_EXCESS_NAK = 2;
  localparam int POS_RECON      = 3;
  localparam int POS_NEW_NID    = 6;
  localparam int POS_RX_INHIB   = 7;
  localparam int NUM_STICKY     = 3;
  localparam int STK_NAK        = 0;
  localparam int STK_RECON      = 1;
  localparam int STK_NID        = 2;

  localparam logic [REG_W-1:0] SRC_MASK =
      (REG_W'(1) << POS_TX_AVAIL)   |
      (REG_W'(1) << POS_EXCESS_NAK) |
      (REG_W'(1) << POS_RECON)      |
      (REG_W'(1) << POS_NEW_NID)    |
      (REG_W'(1) << POS_RX_INHIB);
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_agg_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] VALID = SRC_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) mask_q <= '0;
    else if (wr_en)      mask_q <= wr_data & VALID;
  end

  // R10: software reset wins over a write
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (mask_q == '0));
  // R1: unused positions never hold a written 1
  p_write_filter_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst) |=> ((mask_q & ~VALID) == '0));
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !soft_rst) |=> $stable(mask_q));
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_q[i] <= 1'b0;
      else if (set_ev[i]) flag_q[i] <= 1'b1;
      else if (clr_ev[i]) flag_q[i] <= 1'b0;
    end

    // R9: a set pulse leaves the flag set, even with a clear beside it
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      set_ev[i] |=> flag_q[i]);
    // R5, R6, R7: clear alone drops the flag
    p_clear_only_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_ev[i] && !set_ev[i]) |=> !flag_q[i]);
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!clr_ev[i] && !set_ev[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq_q
);
  logic [W-1:0] gated;
  assign gated = status & mask;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |gated;
  end

  // R3 / R4: the request tracks the enabled sources one cycle later
  p_irq_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (|(status & mask)) |=> irq_q);
  p_irq_hidden_r4: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !irq_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         mask_wr_en,
  input  logic [W-1:0] mask_wr_data,
  output logic [W-1:0] mask_rd,
  input  logic         rx_inhibit_lvl,
  input  logic         tx_avail_lvl,
  input  logic         ev_excess_nak,
  input  logic         ev_recon_timeout,
  input  logic         ev_new_next_id,
  input  logic         clr_flags_cmd,
  input  logic         por_clr_flags_cmd,
  input  logic         next_id_rd,
  output logic [W-1:0] status_word,
  output logic         irq
);
  localparam logic [W-1:0] VALID = W'(SRC_MASK);

  logic [NUM_STICKY-1:0] set_v, clr_v, flag_v;
  logic [W-1:0]          mask_q;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[STK_NAK]   = ev_excess_nak;
    set_v[STK_RECON] = ev_recon_timeout;
    set_v[STK_NID]   = ev_new_next_id;
    clr_v[STK_NAK]   = por_clr_flags_cmd;
    clr_v[STK_RECON] = clr_flags_cmd;
    clr_v[STK_NID]   = next_id_rd;
  end

  irq_mask_reg #(.W(W), .VALID(VALID)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .soft_rst(soft_rst),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_q  (mask_q)
  );

  irq_sticky_bank #(.N(NUM_STICKY)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_ev(set_v),
    .clr_ev(clr_v),
    .flag_q(flag_v)
  );

  always_comb begin
    status_word                 = '0;
    status_word[POS_TX_AVAIL]   = tx_avail_lvl;
    status_word[POS_EXCESS_NAK] = flag_v[STK_NAK];
    status_word[POS_RECON]      = flag_v[STK_RECON];
    status_word[POS_NEW_NID]    = flag_v[STK_NID];
    status_word[POS_RX_INHIB]   = rx_inhibit_lvl;
  end

  irq_combine #(.W(W)) u_comb (
    .clk   (clk),
    .rst   (rst),
    .status(status_word),
    .mask  (mask_q),
    .irq_q (irq)
  );

  assign mask_rd = mask_q;

  // R10: software reset leaves the sticky flags alone
  p_soft_keeps_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && set_v == '0 && clr_v == '0) |=> $stable(flag_v));
  // R11: after a hardware reset nothing is pending
  p_hw_reset_r11: assert property (@(posedge clk)
    rst |=> (!irq && flag_v == '0 && mask_q == '0));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1, soft_rst = 1'b0;
  logic       mask_wr_en = 1'b0;
  logic [7:0] mask_wr_data = '0;
  logic [7:0] mask_rd, status_word;
  logic       rx_inhibit_lvl = 1'b0, tx_avail_lvl = 1'b0;
  logic       ev_excess_nak = 1'b0, ev_recon_timeout = 1'b0, ev_new_next_id = 1'b0;
  logic       clr_flags_cmd = 1'b0, por_clr_flags_cmd = 1'b0, next_id_rd = 1'b0;
  logic       irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_rd(mask_rd),
    .rx_inhibit_lvl(rx_inhibit_lvl), .tx_avail_lvl(tx_avail_lvl),
    .ev_excess_nak(ev_excess_nak), .ev_recon_timeout(ev_recon_timeout),
    .ev_new_next_id(ev_new_next_id), .clr_flags_cmd(clr_flags_cmd),
    .por_clr_flags_cmd(por_clr_flags_cmd), .next_id_rd(next_id_rd),
    .status_word(status_word), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] v);
    mask_wr_en = 1'b1; mask_wr_data = v;
    tick(1);
    mask_wr_en = 1'b0;
  endtask

  task automatic pulse_nak();  ev_excess_nak = 1'b1;    tick(1); ev_excess_nak = 1'b0;    endtask
  task automatic pulse_rec();  ev_recon_timeout = 1'b1; tick(1); ev_recon_timeout = 1'b0; endtask
  task automatic pulse_nid();  ev_new_next_id = 1'b1;   tick(1); ev_new_next_id = 1'b0;   endtask
  task automatic pulse_clr();  clr_flags_cmd = 1'b1;    tick(1); clr_flags_cmd = 1'b0;    endtask
  task automatic pulse_por();  por_clr_flags_cmd = 1'b1; tick(1); por_clr_flags_cmd = 1'b0; endtask
  task automatic pulse_rd();   next_id_rd = 1'b1;       tick(1); next_id_rd = 1'b0;       endtask

  task automatic t_reset();
    check("R11 mask after reset", mask_rd, 8'h00);
    check("R11 status after reset", status_word, 8'h00);
    check("R11 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_unused();
    wr_mask(8'hFF);
    check("R1 unused bits read 0", mask_rd, 8'hCD);
    tick(1);
    check("R1 no source no irq", {7'd0, irq}, 8'h00);
    wr_mask(8'h32);
    check("R1 write to unused only", mask_rd, 8'h00);
  endtask

  task automatic t_levels();
    wr_mask(8'hCD);
    tx_avail_lvl = 1'b1; #0;
    check("R8 tx level same cycle", status_word, 8'h01);
    check("R3 irq not yet", {7'd0, irq}, 8'h00);
    tick(1);
    check("R3 irq one cycle later", {7'd0, irq}, 8'h01);
    tx_avail_lvl = 1'b0; rx_inhibit_lvl = 1'b1; #0;
    check("R2 rx at bit 7", status_word, 8'h80);
    tick(1);
    check("R2 rx raises irq", {7'd0, irq}, 8'h01);
    rx_inhibit_lvl = 1'b0;
    tick(1);
    check("R8 level drop clears irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mask_hide();
    wr_mask(8'h01);
    rx_inhibit_lvl = 1'b1;
    tick(2);
    check("R2 masked source quiet", {7'd0, irq}, 8'h00);
    wr_mask(8'h80); tick(1);
    check("R4 enabled rx irq", {7'd0, irq}, 8'h01);
    wr_mask(8'h00); tick(1);
    check("R4 hidden irq", {7'd0, irq}, 8'h00);
    check("R4 condition kept", status_word, 8'h80);
    wr_mask(8'h80); tick(1);
    check("R4 irq reappears", {7'd0, irq}, 8'h01);
    rx_inhibit_lvl = 1'b0; tick(1);
  endtask

  task automatic t_recon();
    wr_mask(8'h08);
    pulse_rec();
    check("R5 recon flag set", status_word, 8'h08);
    tick(1);
    check("R5 recon irq", {7'd0, irq}, 8'h01);
    pulse_por(); pulse_rd();
    check("R5 other clears ignored", status_word, 8'h08);
    pulse_clr();
    check("R5 clear flags", status_word, 8'h00);
    tick(1);
    check("R5 irq drops", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_nak();
    wr_mask(8'h04);
    pulse_nak();
    check("R6 nak flag at bit 2", status_word, 8'h04);
    tick(1);
    check("R6 nak irq", {7'd0, irq}, 8'h01);
    pulse_clr(); pulse_rd();
    check("R6 other clears ignored", status_word, 8'h04);
    pulse_por();
    check("R6 por clear", status_word, 8'h00);
  endtask

  task automatic t_nid();
    wr_mask(8'h40);
    pulse_nid();
    check("R7 nid flag at bit 6", status_word, 8'h40);
    tick(1);
    check("R7 nid irq", {7'd0, irq}, 8'h01);
    pulse_clr(); pulse_por();
    check("R7 other clears ignored", status_word, 8'h40);
    pulse_rd();
    check("R7 read clears", status_word, 8'h00);
    tick(1);
    check("R7 irq drops", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_wins();
    ev_recon_timeout = 1'b1; clr_flags_cmd = 1'b1;
    ev_excess_nak = 1'b1; por_clr_flags_cmd = 1'b1;
    ev_new_next_id = 1'b1; next_id_rd = 1'b1;
    tick(1);
    {ev_recon_timeout, clr_flags_cmd, ev_excess_nak} = '0;
    {por_clr_flags_cmd, ev_new_next_id, next_id_rd} = '0;
    check("R9 set beats clear", status_word, 8'h4C);
  endtask

  task automatic t_soft_rst();
    wr_mask(8'hCD); tick(1);
    check("R10 irq before soft reset", {7'd0, irq}, 8'h01);
    soft_rst = 1'b1; mask_wr_en = 1'b1; mask_wr_data = 8'hFF;
    tick(1);
    soft_rst = 1'b0; mask_wr_en = 1'b0;
    check("R10 mask cleared over write", mask_rd, 8'h00);
    check("R10 flags kept", status_word, 8'h4C);
    tick(1);
    check("R10 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hw_rst();
    wr_mask(8'hCD); tick(1);
    rst = 1'b1; tick(1); rst = 1'b0;
    check("R11 flags cleared", status_word, 8'h00);
    check("R11 mask cleared", mask_rd, 8'h00);
    check("R11 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst = 1'b0;
    t_reset();
    t_unused();
    t_levels();
    t_mask_hide();
    t_recon();
    t_nak();
    t_nid();
    t_set_wins();
    t_soft_rst();
    t_hw_rst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule